// File: doc/BRIEF.md
# Call Target Guard

This block sits in the execute stage of a pipeline with 40-bit instructions. It makes sure that every subroutine call lands on an instruction that is marked as a legal call target. The call itself never fetches or inspects the word at its destination. Instead, a retiring call arms a one-bit pending flag. The next instruction that actually executes is tested against that flag. If that instruction is not a target marker, the block requests an exception that carries a fixed cause code and the address of the offending instruction.

Each pipeline slot presents a valid bit, a call indicator, a target-marker indicator and the instruction address. A flush input marks the slot as squashed. Only slots that are valid and not flushed count as executed. Bubbles and squashed slots leave the flag untouched. The exception request is registered and appears in the cycle after the offending instruction's slot. Redirecting fetch and servicing the exception are left to the surrounding pipeline.

Top module: `call_target_guard`

## Requirements
- R1: A synchronous active-low reset drives excValid low and disarms the pending flag, so a non-marker instruction executed straight after reset raises nothing, even when a call executed just before reset.
- R2: When the flag is armed and an executed slot has instIsTarget low, excValid is high in the following cycle and excAddr equals that slot's instAddr.
- R3: excCause equals the parameter CAUSE_CODE (default 8'h2C) whenever excValid is high, and is zero whenever excValid is low.
- R4: Each offending instruction yields excValid high for exactly one cycle. A following slot that does not offend sees excValid low.
- R5: When the flag is armed and the executed slot has instIsTarget high, no exception is raised.
- R6: Any executed instruction that is not a call disarms the flag, whether or not it raised an exception.
- R7: A bubble (instValid low) neither tests nor changes the flag, whatever its call and marker inputs.
- R8: A flushed slot (instValid high with flush high) neither tests nor changes the flag, and a flushed call does not arm it.
- R9: An executed call with instIsTarget high satisfies an armed flag without an exception and arms the flag again.
- R10: An executed call with instIsTarget low, seen while the flag is armed, raises an exception and arms the flag again.
- R11: While the flag is disarmed, no executed slot raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | Slot holds a real instruction |
| flush | input | 1 | Slot is squashed by the pipeline |
| instIsCall | input | 1 | Instruction is a subroutine call |
| instIsTarget | input | 1 | Instruction is a call-target marker |
| instAddr | input | ADDR_W (40) | Address of the instruction in the slot |
| excValid | output | 1 | Exception request, one cycle per offender |
| excCause | output | CAUSE_W (8) | Cause code, CAUSE_CODE while excValid is high |
| excAddr | output | ADDR_W (40) | Address of the offending instruction |

## Verification
The bench sweeps every four-slot sequence drawn from six slot kinds: bubble, flushed call, plain, marker, call, and marker call. A reset separates each sequence from the next. Each sequence is therefore tried from a clean state, and a flag left armed across reset is exposed. Sequences that put bubbles or flushed slots between a call and its successor distinguish ignoring those slots from testing or clearing on them. Marker calls and plain calls placed back to back separate "satisfy and re-arm" from "fault and re-arm". Short directed runs then confirm the single-cycle pulse and the cause value on both sides of an exception.

// File: rtl/ctg_pkg.sv
package ctg_pkg;

  // Strobes from control to datapath for one execute slot
  typedef struct packed {
    logic armPend;   // executed call: arm the pending flag
    logic clearPend; // executed non-call: disarm the flag
    logic raise;     // executed non-marker while armed
  } ctgStrobe_t;

endpackage

// File: rtl/ctg_ctrl.sv
module ctg_ctrl
  import ctg_pkg::*;
(
  input  logic       instValid,
  input  logic       flush,
  input  logic       instIsCall,
  input  logic       instIsTarget,
  input  logic       pendQ,
  output ctgStrobe_t strobe
);

  logic execSlot;

  // only valid, non-squashed slots take part in the check
  assign execSlot = instValid & ~flush;

  always_comb begin
    strobe           = '0;
    strobe.raise     = execSlot & pendQ & ~instIsTarget;
    strobe.armPend   = execSlot & instIsCall;
    strobe.clearPend = execSlot & ~instIsCall;
  end

endmodule

// File: rtl/ctg_datapath.sv
module ctg_datapath
  import ctg_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CAUSE_W = 8,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 8'h2C
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctgStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  instAddr,
  output logic               pendQ,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [ADDR_W-1:0]  excAddr
);

  logic              excValidQ;
  logic [ADDR_W-1:0] excAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (strobe.armPend) begin
      pendQ <= 1'b1;
    end else if (strobe.clearPend) begin
      pendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValidQ <= 1'b0;
      excAddrQ  <= '0;
    end else begin
      excValidQ <= strobe.raise;
      if (strobe.raise) begin
        excAddrQ <= instAddr;
      end
    end
  end

  assign excValid = excValidQ;
  assign excAddr  = excAddrQ;
  assign excCause = excValidQ ? CAUSE_CODE : '0;

endmodule

// File: rtl/call_target_guard.sv
module call_target_guard
  import ctg_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CAUSE_W = 8,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 8'h2C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic               flush,
  input  logic               instIsCall,
  input  logic               instIsTarget,
  input  logic [ADDR_W-1:0]  instAddr,
  output logic               excValid,
  output logic [CAUSE_W-1:0] excCause,
  output logic [ADDR_W-1:0]  excAddr
);

  ctgStrobe_t strobe;
  logic       pendQ;

  ctg_ctrl u_ctrl (
    .instValid    (instValid),
    .flush        (flush),
    .instIsCall   (instIsCall),
    .instIsTarget (instIsTarget),
    .pendQ        (pendQ),
    .strobe       (strobe)
  );

  ctg_datapath #(
    .ADDR_W     (ADDR_W),
    .CAUSE_W    (CAUSE_W),
    .CAUSE_CODE (CAUSE_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .instAddr (instAddr),
    .pendQ    (pendQ),
    .excValid (excValid),
    .excCause (excCause),
    .excAddr  (excAddr)
  );

endmodule

// File: rtl/ctg_chk.sv
module ctg_chk #(
  parameter int ADDR_W = 40,
  parameter int CAUSE_W = 8,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 8'h2C
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic               flush,
  input logic               instIsCall,
  input logic               instIsTarget,
  input logic [ADDR_W-1:0]  instAddr,
  input logic               pendingFlag,
  input logic               excValid,
  input logic [CAUSE_W-1:0] excCause,
  input logic [ADDR_W-1:0]  excAddr
);

  // R2
  fault_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !flush && !instIsTarget && pendingFlag) |=>
      (excValid && excAddr == $past(instAddr)));

  // R3
  cause_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> excCause == CAUSE_CODE);

  // R5
  target_no_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !flush && instIsTarget) |=> !excValid);

  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !flush && !instIsCall) |=> !pendingFlag);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && !flush) |=> $stable(pendingFlag));

  // R8
  exc_needs_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(instValid && !flush));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !flush && instIsCall) |=> pendingFlag);

  // R11
  no_pend_no_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendingFlag |=> !excValid);

endmodule

bind call_target_guard ctg_chk #(
  .ADDR_W     (ADDR_W),
  .CAUSE_W    (CAUSE_W),
  .CAUSE_CODE (CAUSE_CODE)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .instValid    (instValid),
  .flush        (flush),
  .instIsCall   (instIsCall),
  .instIsTarget (instIsTarget),
  .instAddr     (instAddr),
  .pendingFlag  (pendQ),
  .excValid     (excValid),
  .excCause     (excCause),
  .excAddr      (excAddr)
);

// File: tb/sim_call_target_guard.sv
`timescale 1ns/1ps
module sim_call_target_guard;

  localparam int ADDR_W = 40;
  localparam int CAUSE_W = 8;
  localparam logic [CAUSE_W-1:0] CAUSE = 8'h2C;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               instValid = 1'b0;
  logic               flush = 1'b0;
  logic               instIsCall = 1'b0;
  logic               instIsTarget = 1'b0;
  logic [ADDR_W-1:0]  instAddr = '0;
  logic               excValid;
  logic [CAUSE_W-1:0] excCause;
  logic [ADDR_W-1:0]  excAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  call_target_guard #(
    .ADDR_W     (ADDR_W),
    .CAUSE_W    (CAUSE_W),
    .CAUSE_CODE (CAUSE)
  ) u0 (
    .clk          (clk),
    .rstN         (rstN),
    .instValid    (instValid),
    .flush        (flush),
    .instIsCall   (instIsCall),
    .instIsTarget (instIsTarget),
    .instAddr     (instAddr),
    .excValid     (excValid),
    .excCause     (excCause),
    .excAddr      (excAddr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kinds: 0 bubble, 1 flushed call, 2 plain, 3 marker, 4 call, 5 marker call
  task automatic drive(input int kind, input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    instValid    = (kind != 0);
    flush        = (kind == 1);
    instIsCall   = (kind == 0 || kind == 1 || kind == 4 || kind == 5);
    instIsTarget = (kind == 3 || kind == 5);
    instAddr     = addr;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    flush     = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    instValid = 1'b0;
    flush = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 excValid after reset", excValid, 0);
    check("R3 cause idle after reset", excCause, 0);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // directed: R1 reset clears an armed flag
    doReset();
    drive(4, 40'h10);
    doReset();
    drive(2, 40'h14);
    check("R1 no fault after reset", excValid, 0);

    // directed: R4 single pulse, R3 cause around it
    drive(4, 40'h20);
    drive(2, 40'hAB_CDEF_0123);
    check("R4 pulse present", excValid, 1);
    check("R3 cause on fault", excCause, CAUSE);
    check("R2 fault address", excAddr, 40'hAB_CDEF_0123);
    drive(0, 40'h28);
    check("R4 pulse gone", excValid, 0);
    check("R3 cause cleared", excCause, 0);

    // exhaustive sweep of four-slot sequences
    for (int seq = 0; seq < 1296; seq++) begin
      bit pend;
      bit prevFault;
      int rem;
      doReset();
      pend = 0;
      prevFault = 0;
      rem = seq;
      for (int s = 0; s < 4; s++) begin
        int kind;
        bit exec;
        bit isCall;
        bit isTgt;
        bit fault;
        string tag;
        logic [ADDR_W-1:0] addr;
        kind = rem % 6;
        rem = rem / 6;
        exec = (kind >= 2);
        isCall = (kind == 4 || kind == 5);
        isTgt = (kind == 3 || kind == 5);
        fault = exec && pend && !isTgt;
        if (!exec) tag = (kind == 0) ? "R7" : "R8";
        else if (fault) tag = isCall ? "R10" : "R2";
        else if (pend) tag = isCall ? "R9" : "R5";
        else if (prevFault) tag = "R6";
        else tag = "R11";
        if (prevFault && !fault) tag = {tag, " R4"};
        addr = 40'(seq) * 40'h1000 + 40'(s) * 40'h5 + 40'h8000_0000;
        drive(kind, addr);
        check({tag, " excValid"}, excValid, fault);
        if (fault) begin
          check({tag, " excAddr"}, excAddr, addr);
          check("R3 cause", excCause, CAUSE);
        end else begin
          check("R3 cause zero", excCause, 0);
        end
        if (exec) pend = isCall;
        prevFault = fault;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule